// File: doc/BRIEF.md
# Serial-Loaded Solenoid Hit-and-Hold Driver

This controller drives a bank of solenoid channels. A host shifts a channel-select word in one bit at a time on a shift clock. It then pulses a strobe, which copies the word into an output latch. Every channel whose latch bit is set is driven fully on for a pull-in interval, so the plunger seats. After that the channel is held with a low-duty pulse-width-modulated signal, which keeps the solenoid engaged at a fraction of the dissipation.

For as long as the strobe input stays high, the selected outputs stay continuously on, whatever the modulator is doing. A new strobe at any time latches the freshly shifted word and starts a new pull-in interval. After reset, a power-on quiet window keeps every output low while the host is still setting up, whatever the latch holds.

The shift clock, serial data and strobe inputs are sampled on the system clock. They must already be synchronous to it and held for at least one system clock cycle per level. Timing parameters are given in system clock cycles. By default they are derived from the clock frequency: half a second of pull-in, a 1 kHz modulation period and 25 % on time.

Top module: `solhold_driver`

## Requirements
- R1: While `rst` is high, `drive` is all zeros. Reset clears the shift register and the latch.
- R2: On each system clock edge where `sclk` is high and was low at the previous edge, the shift register moves one place toward the MSB and takes `sdata` into bit 0. After CH such rising edges, the first bit shifted is in bit CH-1. Shifting alone never changes `drive`.
- R3: At the first edge where `strobe` is seen high after being low, the shift register is copied into the latch. From the next sample onward, `drive` equals the latch for PULL_CYC consecutive cycles.
- R4: After the pull-in interval, `drive` equals the latch for the first ON cycles of each PWM_CYC-cycle period and is zero for the rest. ON is PWM_CYC*DUTY_PCT/100, and the first period starts right after the pull-in ends.
- R5: While `strobe` remains high, `drive` equals the latch in every cycle, including cycles the modulator would hold low.
- R6: A strobe rising during the hold phase latches the new word and restarts a full PULL_CYC pull-in with it.
- R7: A channel whose latch bit is 0 has its `drive` bit at 0 in every phase. Bit i of `drive` belongs to latch bit i.
- R8: After the quiet window, before any strobe since reset, `drive` is zero.
- R9: For the first POR_CYC-1 clock edges after `rst` falls, `drive` is zero, even when a strobe has already latched a word. Strobes and shifting during this window still take effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | Shift clock, sampled on `clk` |
| sdata | input | 1 | Serial channel-select data, MSB first |
| strobe | input | 1 | Latch transfer and full-on override |
| drive | output | CH | Per-channel solenoid drive, high means on |

## Verification
A wrong pull-in counter shows up at the ports on the exact cycle where a fully on output first drops to the modulated pattern. That cycle is early or late against PULL_CYC counted from the strobe. A wrong modulation counter or phase changes the on/off pattern within the first hold period, so the bench compares `drive` every cycle and catches it within PWM_CYC cycles. A latch or shift register that is corrupted, or loaded in the wrong order, shows as a wrong bit pattern on the first full-on cycle after the strobe. A quiet-window counter off by one shows as outputs rising one cycle early or late at the boundary of that window.

// File: rtl/solhold_pkg.sv
package solhold_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PULL = 2'd1,
        PH_HOLD = 2'd2
    } phase_e;

    // width needed to hold the value n (at least one bit)
    function automatic int cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

    // on-cycles of one modulation period for a duty given in percent
    function automatic int duty_cycles(input int period, input int pct);
        return (period * pct) / 100;
    endfunction

endpackage

// File: rtl/solhold_sipo.sv
module solhold_sipo #(
    parameter int CH = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          sdata,
    input  logic          load,
    output logic [CH-1:0] shreg_o,
    output logic [CH-1:0] latch_o
);
    logic          sclk_q;
    logic [CH-1:0] shreg;
    logic [CH-1:0] latch;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
            latch  <= '0;
        end else begin
            sclk_q <= sclk;
            if (sclk && !sclk_q)
                shreg <= {shreg[CH-2:0], sdata};
            if (load)
                latch <= shreg;
        end
    end

    assign shreg_o = shreg;
    assign latch_o = latch;
endmodule

// File: rtl/solhold_seq.sv
module solhold_seq
    import solhold_pkg::*;
#(
    parameter int PULL_CYC = 500000,
    parameter int PWM_CYC  = 1000,
    parameter int ON_CYC   = 250
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   restart,
    output phase_e phase_o,
    output logic   full_o,
    output logic   pwm_on_o
);
    localparam int PW = cnt_w(PULL_CYC);
    localparam int QW = cnt_w(PWM_CYC);

    phase_e        phase;
    logic [PW-1:0] pull_cnt;
    logic [QW-1:0] pwm_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            pull_cnt <= '0;
            pwm_cnt  <= '0;
        end else if (restart) begin
            phase    <= PH_PULL;
            pull_cnt <= PW'(PULL_CYC - 1);
            pwm_cnt  <= '0;
        end else begin
            case (phase)
                PH_PULL: begin
                    if (pull_cnt == '0) begin
                        phase   <= PH_HOLD;
                        pwm_cnt <= '0;
                    end else begin
                        pull_cnt <= pull_cnt - 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (pwm_cnt == QW'(PWM_CYC - 1))
                        pwm_cnt <= '0;
                    else
                        pwm_cnt <= pwm_cnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    assign phase_o  = phase;
    assign full_o   = (phase == PH_PULL);
    assign pwm_on_o = (phase == PH_HOLD) && (pwm_cnt < QW'(ON_CYC));
endmodule

// File: rtl/solhold_por.sv
module solhold_por
    import solhold_pkg::*;
#(
    parameter int POR_CYC = 10000
) (
    input  logic clk,
    input  logic rst,
    output logic busy_o
);
    localparam int W = cnt_w(POR_CYC);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= W'(POR_CYC);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy_o = (cnt != '0);
endmodule

// File: rtl/solhold_driver.sv
module solhold_driver
    import solhold_pkg::*;
#(
    parameter int CH       = 8,
    parameter int CLK_HZ   = 1000000,
    parameter int PULL_CYC = CLK_HZ / 2,
    parameter int PWM_CYC  = CLK_HZ / 1000,
    parameter int DUTY_PCT = 25,
    parameter int POR_CYC  = CLK_HZ / 100
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          sdata,
    input  logic          strobe,
    output logic [CH-1:0] drive
);
    localparam int ON_CYC = duty_cycles(PWM_CYC, DUTY_PCT);

    logic          stb_q;
    logic          stb_rise;
    logic [CH-1:0] shreg_w;
    logic [CH-1:0] latch_w;
    phase_e        phase_w;
    logic          full_w;
    logic          pwm_on_w;
    logic          por_busy;
    logic          ch_en;

    always_ff @(posedge clk) begin
        if (rst) stb_q <= 1'b0;
        else     stb_q <= strobe;
    end

    assign stb_rise = strobe && !stb_q;

    solhold_sipo #(.CH(CH)) u_sipo (
        .clk     (clk),
        .rst     (rst),
        .sclk    (sclk),
        .sdata   (sdata),
        .load    (stb_rise),
        .shreg_o (shreg_w),
        .latch_o (latch_w)
    );

    solhold_seq #(
        .PULL_CYC (PULL_CYC),
        .PWM_CYC  (PWM_CYC),
        .ON_CYC   (ON_CYC)
    ) u_seq (
        .clk      (clk),
        .rst      (rst),
        .restart  (stb_rise),
        .phase_o  (phase_w),
        .full_o   (full_w),
        .pwm_on_o (pwm_on_w)
    );

    solhold_por #(.POR_CYC(POR_CYC)) u_por (
        .clk    (clk),
        .rst    (rst),
        .busy_o (por_busy)
    );

    assign ch_en = !por_busy && (full_w || stb_q || pwm_on_w);

    for (genvar g = 0; g < CH; g++) begin : g_ch
        assign drive[g] = latch_w[g] & ch_en;
    end
endmodule

// File: rtl/solhold_chk.sv
module solhold_chk
    import solhold_pkg::*;
#(
    parameter int CH = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          sclk,
    input logic          sdata,
    input logic          strobe,
    input logic          stb_q,
    input logic [CH-1:0] shreg_w,
    input logic [CH-1:0] latch_w,
    input phase_e        phase_w,
    input logic          por_busy,
    input logic [CH-1:0] drive
);
    logic sclk_p;

    always_ff @(posedge clk) begin
        if (rst) sclk_p <= 1'b0;
        else     sclk_p <= sclk;
    end

    a_r1_reset_off: assert property (@(posedge clk) rst |=> (drive == '0 || rst));

    a_r2_shift_in: assert property (@(posedge clk) disable iff (rst)
        (sclk && !sclk_p) |=> (shreg_w[0] == $past(sdata)));

    a_r3_pull_full: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_PULL && !por_busy) |-> (drive == latch_w));

    a_r4_hold_levels: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_HOLD && !stb_q && !por_busy) |-> (drive == latch_w || drive == '0));

    a_r5_strobe_full: assert property (@(posedge clk) disable iff (rst)
        (stb_q && !por_busy) |-> (drive == latch_w));

    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (strobe && !stb_q) |=> (phase_w == PH_PULL && latch_w == $past(shreg_w)));

    a_r7_unselected: assert property (@(posedge clk) disable iff (rst)
        (drive & ~latch_w) == '0);

    a_r8_idle_off: assert property (@(posedge clk) disable iff (rst)
        (phase_w == PH_IDLE && !stb_q) |-> (drive == '0));

    a_r9_por_quiet: assert property (@(posedge clk) disable iff (rst)
        por_busy |-> (drive == '0));
endmodule

bind solhold_driver solhold_chk #(.CH(CH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sclk     (sclk),
    .sdata    (sdata),
    .strobe   (strobe),
    .stb_q    (stb_q),
    .shreg_w  (shreg_w),
    .latch_w  (latch_w),
    .phase_w  (phase_w),
    .por_busy (por_busy),
    .drive    (drive)
);

// File: tb/sim_solhold_driver.sv
module sim_solhold_driver;
    localparam int CLK_NS = 10;
    localparam int CH     = 8;
    localparam int PULL   = 30;
    localparam int PER    = 8;
    localparam int DUTY   = 25;
    localparam int ON     = PER * DUTY / 100;
    localparam int POR    = 40;

    // vector: [15:8] word shifted in, [7:0] expected full-on drive (R7: clear bits stay 0)
    localparam logic [15:0] VEC [0:5] = '{
        16'hA5A5, 16'h3C3C, 16'h0101, 16'h8080, 16'hFFFF, 16'h0000
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          sclk = 1'b0;
    logic          sdata = 1'b0;
    logic          strobe = 1'b0;
    logic [CH-1:0] drive;

    int   n_chk = 0;
    int   n_fail = 0;
    int   k = 0;
    int   hj = 0;
    logic [7:0] hpat = '0;
    bit   done = 1'b0;

    always #(CLK_NS / 2) clk = ~clk;

    solhold_driver #(
        .CH       (CH),
        .CLK_HZ   (1000),
        .PULL_CYC (PULL),
        .PWM_CYC  (PER),
        .DUTY_PCT (DUTY),
        .POR_CYC  (POR)
    ) u0 (
        .clk    (clk),
        .rst    (rst),
        .sclk   (sclk),
        .sdata  (sdata),
        .strobe (strobe),
        .drive  (drive)
    );

    task automatic check(input logic [7:0] exp, input string tag);
        n_chk++;
        if (drive !== exp) begin
            n_fail++;
            $display("FAIL %s: drive=%h expected=%h (sample %0d)", tag, drive, exp, k);
        end
    endtask

    task automatic step(input logic [7:0] exp, input string tag);
        @(negedge clk);
        k++;
        check(exp, tag);
    endtask

    task automatic hold_step(input string tag);
        step(((hj % PER) < ON) ? hpat : 8'h00, tag);
        hj++;
    endtask

    task automatic shift_word(input logic [7:0] w, input string tag);
        for (int b = 7; b >= 0; b--) begin
            sdata = w[b];
            sclk  = 1'b1;
            hold_step(tag);
            sclk  = 1'b0;
            hold_step(tag);
        end
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(CLK_NS * 50000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        // R1: outputs off during reset
        for (int i = 0; i < 3; i++) step(8'h00, "R1");
        rst = 1'b0;
        k = 0;

        // R9: word loaded and strobed inside the quiet window
        hpat = 8'h00;
        hj = 0;
        shift_word(8'hFF, "R9");
        strobe = 1'b1;
        for (int i = 0; i < PULL; i++) begin
            @(negedge clk);
            k++;
            strobe = 1'b0;
            check((k < POR) ? 8'h00 : 8'hFF, "R9");
        end
        hpat = 8'hFF;
        hj = 0;
        for (int i = 0; i < 2 * PER; i++) hold_step("R4");

        // table: shift (R2, outputs unchanged), strobe in hold (R6), pull-in (R3), hold (R4)
        for (int i = 0; i < 6; i++) begin
            shift_word(VEC[i][15:8], "R2");
            strobe = 1'b1;
            step(VEC[i][7:0], "R6");
            strobe = 1'b0;
            for (int c = 1; c < PULL; c++) step(VEC[i][7:0], "R3");
            hpat = VEC[i][7:0];
            hj = 0;
            for (int c = 0; c < 2 * PER; c++) hold_step("R4");
        end

        // R7: single channel in the middle of the word
        shift_word(8'h10, "R2");
        strobe = 1'b1;
        step(8'h10, "R7");
        strobe = 1'b0;
        for (int c = 1; c < PULL; c++) step(8'h10, "R7");
        hpat = 8'h10;
        hj = 0;
        for (int c = 0; c < PER; c++) hold_step("R7");

        // R5: strobe held past the pull-in keeps outputs on
        shift_word(8'h5A, "R2");
        strobe = 1'b1;
        for (int c = 0; c < PULL + 12; c++) step(8'h5A, "R5");
        strobe = 1'b0;
        hpat = 8'h5A;
        hj = 12;
        for (int c = 0; c < 2 * PER; c++) hold_step("R4");

        // R1 again mid-hold, then R8: idle after the quiet window with a cleared latch
        rst = 1'b1;
        step(8'h00, "R1");
        step(8'h00, "R1");
        rst = 1'b0;
        k = 0;
        for (int c = 0; c < POR + 5; c++) step(8'h00, "R8");
        strobe = 1'b1;
        step(8'h00, "R1");
        strobe = 1'b0;
        for (int c = 0; c < 4; c++) step(8'h00, "R1");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule